// File: doc/BRIEF.md
# USB Data Toggle Guard

This block sits in the receive path of a USB device controller, after PID decoding and the CRC check. For every received data packet it looks up a one-bit sequence state for the addressed endpoint and direction, and compares the packet's DATA0/DATA1 type with that state. When they agree, the packet is new: it is accepted, handed on to software, and the stored bit flips. When they differ, the packet is a retransmission of one already taken in. It is dropped without being reported, but it is still given a positive handshake so that the host moves on.

A test-only inhibit input bypasses the comparison, so every good packet is accepted. An endpoint clear strobe returns both directions of one endpoint to DATA0, as needed after a configuration change or a halt clear. The handshake choice between ACK and NYET depends on whether the link runs at high speed and whether the endpoint has room for the next packet. Each decision appears on registered outputs one clock after the packet strobe.

Top module: `usb_toggle_guard`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every toggle slot holds DATA0 and all result outputs are 0.
- R2: A packet strobe is answered exactly one cycle later by a one-cycle `res_valid` pulse. No `res_valid` appears without a strobe in the cycle before.
- R3: A good packet (CRC good, endpoint below `NUM_EP`, inhibit clear) whose type bit (0 = DATA0, 1 = DATA1) equals the stored bit of slot `2*ep + dir` is accepted: `res_accept` and `res_deliver` are 1 and `res_discard` is 0.
- R4: Each accepted packet inverts the stored bit of its own slot only. No other slot changes.
- R5: A good packet whose type bit differs from the stored bit, with inhibit clear, is discarded: `res_discard` is 1, `res_accept` and `res_deliver` are 0, and the stored bit is unchanged.
- R6: A discarded packet still gets a positive handshake. `res_hs` is never 0 (no handshake) when `res_discard` is 1.
- R7: For every good packet, accepted or discarded, `res_hs` is 2'b10 (NYET) when `hs_mode` and `buf_full` are both 1, and 2'b01 (ACK) otherwise.
- R8: A packet with `pkt_crc_ok` low gives `res_valid` with `res_accept`, `res_discard`, `res_deliver` at 0 and `res_hs` 2'b00, and it leaves all toggle state unchanged.
- R9: With `tog_inhibit` at 1, every good packet is accepted and delivered whatever its type bit, and its slot still inverts.
- R10: `ep_clr` sets both direction slots of endpoint `ep_clr_idx` to DATA0. A packet in the same cycle is judged against the old value, and the clear wins the final state.
- R11: A packet addressed to an endpoint at or above `NUM_EP` gets `res_valid` with no accept, no discard, no delivery, `res_hs` 2'b00, and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | One-cycle strobe for a received data packet |
| pkt_ep | input | EP_W | Endpoint number of the packet |
| pkt_dir | input | 1 | Direction half of the slot (slot = 2*ep + dir) |
| pkt_data1 | input | 1 | Packet type: 0 DATA0, 1 DATA1 |
| pkt_crc_ok | input | 1 | Packet passed the CRC check |
| hs_mode | input | 1 | Link runs at high speed |
| buf_full | input | 1 | Endpoint has no room for another packet |
| tog_inhibit | input | 1 | Test-only: skip the toggle comparison |
| ep_clr | input | 1 | Strobe: return an endpoint to DATA0 |
| ep_clr_idx | input | EP_W | Endpoint cleared by `ep_clr` |
| res_valid | output | 1 | Decision present for the previous strobe |
| res_accept | output | 1 | Packet is new and is taken in |
| res_discard | output | 1 | Packet is a duplicate and is dropped |
| res_deliver | output | 1 | Packet is handed on to software |
| res_hs | output | 2 | Handshake: 00 none, 01 ACK, 10 NYET |

## Verification
The properties assume that `pkt_valid` is a clean strobe and that the packet fields are stable while it is high. They also assume `tog_inhibit` changes only between packets, so each decision has a single well-defined inhibit value. The bench drives every input on the falling edge and holds it for exactly one cycle. It sweeps all endpoint, direction, type, CRC, inhibit, speed and buffer combinations in a fixed order, and it includes an endpoint number above the configured count. A running reference of all slots tells the bench whether each packet should count as new or as a duplicate.

// File: rtl/usb_tog_pkg.sv
package usb_tog_pkg;

  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NYET = 2'b10
  } hs_code_e;

  typedef struct packed {
    logic     accept;
    logic     discard;
    logic     deliver;
    hs_code_e hs;
  } verdict_t;

  // a packet is fresh when the stored sequence bit agrees, or the check is bypassed
  function automatic logic seq_fresh(input logic bypass, input logic pkt_bit,
                                     input logic held_bit);
    return bypass | (pkt_bit == held_bit);
  endfunction

  // positive handshake selection for any packet that is answered
  function automatic hs_code_e pick_hs(input logic answered, input logic high_speed,
                                       input logic no_room);
    if (!answered)              return HS_NONE;
    if (high_speed && no_room)  return HS_NYET;
    return HS_ACK;
  endfunction

endpackage

// File: rtl/tog_store.sv
module tog_store #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EP_W:0]   rd_slot,
  output logic            rd_bit,
  input  logic            wr_flip,
  input  logic [EP_W:0]   wr_slot,
  input  logic            clr_en,
  input  logic [EP_W-1:0] clr_ep
);
  localparam int SLOTS   = NUM_EP * 2;
  localparam int SLOTS_P = 1 << (EP_W + 1);

  logic [SLOTS_P-1:0] seq_vec;

  genvar s;
  generate
    for (s = 0; s < SLOTS_P; s++) begin : g_slot
      if (s < SLOTS) begin : g_real
        logic clr_hit;
        logic flip_hit;
        assign clr_hit  = clr_en && (clr_ep == EP_W'(s / 2));
        assign flip_hit = wr_flip && (wr_slot == (EP_W + 1)'(s));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)        seq_vec[s] <= 1'b0;
          else if (clr_hit)  seq_vec[s] <= 1'b0;
          else if (flip_hit) seq_vec[s] <= ~seq_vec[s];
        end
      end else begin : g_pad
        assign seq_vec[s] = 1'b0;
      end
    end
  endgenerate

  assign rd_bit = seq_vec[rd_slot];
endmodule

// File: rtl/tog_decide.sv
module tog_decide
  import usb_tog_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2
) (
  input  logic            pkt_valid,
  input  logic [EP_W-1:0] pkt_ep,
  input  logic            pkt_data1,
  input  logic            pkt_crc_ok,
  input  logic            hs_mode,
  input  logic            buf_full,
  input  logic            tog_inhibit,
  input  logic            held_bit,
  output logic            good_ev,
  output logic            flip_ev,
  output verdict_t        verdict
);
  logic in_range;
  logic fresh;

  assign in_range = ({1'b0, pkt_ep} < (EP_W + 1)'(NUM_EP));
  assign good_ev  = pkt_valid && in_range && pkt_crc_ok;
  assign fresh    = seq_fresh(tog_inhibit, pkt_data1, held_bit);

  always_comb begin
    verdict.accept  = good_ev && fresh;
    verdict.discard = good_ev && !fresh;
    verdict.deliver = good_ev && fresh;
    verdict.hs      = pick_hs(good_ev, hs_mode, buf_full);
  end

  assign flip_ev = good_ev && fresh;
endmodule

// File: rtl/tog_resp.sv
module tog_resp
  import usb_tog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe,
  input  verdict_t verdict,
  output logic     res_valid,
  output verdict_t res_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_q     <= '{accept: 1'b0, discard: 1'b0, deliver: 1'b0, hs: HS_NONE};
    end else begin
      res_valid <= strobe;
      if (strobe) res_q <= verdict;
      else        res_q <= '{accept: 1'b0, discard: 1'b0, deliver: 1'b0, hs: HS_NONE};
    end
  end
endmodule

// File: rtl/usb_toggle_guard.sv
module usb_toggle_guard
  import usb_tog_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_valid,
  input  logic [EP_W-1:0] pkt_ep,
  input  logic            pkt_dir,
  input  logic            pkt_data1,
  input  logic            pkt_crc_ok,
  input  logic            hs_mode,
  input  logic            buf_full,
  input  logic            tog_inhibit,
  input  logic            ep_clr,
  input  logic [EP_W-1:0] ep_clr_idx,
  output logic            res_valid,
  output logic            res_accept,
  output logic            res_discard,
  output logic            res_deliver,
  output logic [1:0]      res_hs
);
  logic [EP_W:0] slot_idx;
  logic          held_bit;
  logic          good_ev;
  logic          flip_ev;
  verdict_t      verdict;
  verdict_t      res_q;

  assign slot_idx = {pkt_ep, pkt_dir};

  tog_store #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_slot (slot_idx),
    .rd_bit  (held_bit),
    .wr_flip (flip_ev),
    .wr_slot (slot_idx),
    .clr_en  (ep_clr),
    .clr_ep  (ep_clr_idx)
  );

  tog_decide #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_decide (
    .pkt_valid   (pkt_valid),
    .pkt_ep      (pkt_ep),
    .pkt_data1   (pkt_data1),
    .pkt_crc_ok  (pkt_crc_ok),
    .hs_mode     (hs_mode),
    .buf_full    (buf_full),
    .tog_inhibit (tog_inhibit),
    .held_bit    (held_bit),
    .good_ev     (good_ev),
    .flip_ev     (flip_ev),
    .verdict     (verdict)
  );

  tog_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (pkt_valid),
    .verdict   (verdict),
    .res_valid (res_valid),
    .res_q     (res_q)
  );

  assign res_accept  = res_q.accept;
  assign res_discard = res_q.discard;
  assign res_deliver = res_q.deliver;
  assign res_hs      = res_q.hs;
endmodule

// File: rtl/usb_toggle_guard_chk.sv
module usb_toggle_guard_chk #(
  parameter int NUM_EP = 4,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pkt_valid,
  input logic [EP_W-1:0] pkt_ep,
  input logic            pkt_crc_ok,
  input logic            hs_mode,
  input logic            buf_full,
  input logic            tog_inhibit,
  input logic            res_valid,
  input logic            res_accept,
  input logic            res_discard,
  input logic            res_deliver,
  input logic [1:0]      res_hs
);
  logic ep_ok;
  assign ep_ok = ({1'b0, pkt_ep} < (EP_W + 1)'(NUM_EP));

  // R2
  resp_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> res_valid);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !res_valid);
  // R3
  accept_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_accept && res_discard));
  // R5
  discard_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_discard |-> !res_deliver);
  // R6
  discard_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_discard |-> (res_hs != 2'b00));
  // R7
  nyet_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && ep_ok && pkt_crc_ok && hs_mode && buf_full) |=> (res_hs == 2'b10));
  // R8
  bad_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_crc_ok) |=> (!res_accept && !res_discard && res_hs == 2'b00));
  // R9
  inhibit_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && ep_ok && pkt_crc_ok && tog_inhibit) |=> (res_accept && res_deliver));
  // R11
  range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !ep_ok) |=> (!res_accept && !res_discard && res_hs == 2'b00));
endmodule

bind usb_toggle_guard usb_toggle_guard_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/usb_toggle_guard_tb.sv
module usb_toggle_guard_tb;
  localparam int NUM_EP = 3;
  localparam int EP_W   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pkt_valid = 1'b0;
  logic [EP_W-1:0] pkt_ep = '0;
  logic            pkt_dir = 1'b0;
  logic            pkt_data1 = 1'b0;
  logic            pkt_crc_ok = 1'b0;
  logic            hs_mode = 1'b0;
  logic            buf_full = 1'b0;
  logic            tog_inhibit = 1'b0;
  logic            ep_clr = 1'b0;
  logic [EP_W-1:0] ep_clr_idx = '0;
  logic            res_valid, res_accept, res_discard, res_deliver;
  logic [1:0]      res_hs;

  int checks = 0;
  int fails  = 0;
  logic ref_tog [0:7];

  always #2 clk = ~clk;  // 250 MHz

  usb_toggle_guard #(.NUM_EP(NUM_EP)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // call on a falling edge; returns on the falling edge where the result is sampled
  task automatic send(input int ep, input int dir, input int d1, input int crc,
                      input int inh, input int hsm, input int full,
                      input int clr, input int clr_ep);
    int slot;
    bit good, fresh;
    int exp_hs;
    slot  = ep * 2 + dir;
    good  = (ep < NUM_EP) && (crc != 0);
    fresh = (inh != 0) || (d1 == int'(ref_tog[slot]));
    exp_hs = !good ? 0 : ((hsm != 0 && full != 0) ? 2 : 1);
    pkt_valid = 1'b1; pkt_ep = EP_W'(ep); pkt_dir = dir[0]; pkt_data1 = d1[0];
    pkt_crc_ok = crc[0]; tog_inhibit = inh[0]; hs_mode = hsm[0]; buf_full = full[0];
    ep_clr = clr[0]; ep_clr_idx = EP_W'(clr_ep);
    @(negedge clk);
    pkt_valid = 1'b0; ep_clr = 1'b0;
    check("R2 res_valid", int'(res_valid), 1);
    if (ep >= NUM_EP) begin
      check("R11 accept", int'(res_accept), 0);
      check("R11 handshake", int'(res_hs), 0);
    end else if (crc == 0) begin
      check("R8 accept", int'(res_accept), 0);
      check("R8 discard", int'(res_discard), 0);
      check("R8 handshake", int'(res_hs), 0);
    end else begin
      if (inh != 0) check("R9 accept", int'(res_accept), 1);
      else if (fresh) check("R3 accept", int'(res_accept), 1);
      else check("R5 discard", int'(res_discard), 1);
      check("R3 deliver", int'(res_deliver), int'(fresh));
      check("R5 discard flag", int'(res_discard), int'(!fresh));
      if (!fresh) check("R6 handshake", int'(res_hs != 0), 1);
      check("R7 handshake", int'(res_hs), exp_hs);
    end
    if (good && fresh) ref_tog[slot] = ~ref_tog[slot];  // R4
    if (clr != 0) begin                                  // R10
      ref_tog[clr_ep * 2]     = 1'b0;
      ref_tog[clr_ep * 2 + 1] = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_tog[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset valid", int'(res_valid), 0);
    check("R1 reset hs", int'(res_hs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(res_valid | res_accept | res_deliver), 0);
    // R1: every slot starts at DATA0
    for (int s = 0; s < NUM_EP * 2; s++) send(s / 2, s % 2, 0, 1, 0, 0, 0, 0, 0);
    // near-exhaustive sweep
    for (int rep = 0; rep < 2; rep++)
      for (int inh = 0; inh < 2; inh++)
        for (int hsm = 0; hsm < 2; hsm++)
          for (int full = 0; full < 2; full++)
            for (int crc = 0; crc < 2; crc++)
              for (int d1 = 0; d1 < 2; d1++)
                for (int ep = 0; ep < 4; ep++)
                  for (int dir = 0; dir < 2; dir++)
                    send(ep, dir, d1, crc, inh, hsm, full, 0, 0);
    // R2: no response without a strobe
    @(negedge clk);
    check("R2 idle", int'(res_valid), 0);
    // R10: drive endpoint 1 both slots to DATA1, then clear
    for (int dir = 0; dir < 2; dir++)
      if (ref_tog[2 + dir] == 1'b0) send(1, dir, 0, 1, 0, 0, 0, 0, 0);
    send(0, 0, int'(ref_tog[0]), 1, 0, 0, 0, 1, 1);  // clear alongside another packet
    send(1, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R10 out slot cleared", int'(ref_tog[2]), 1);
    send(1, 1, 0, 1, 0, 0, 0, 0, 0);
    // R10: same-cycle packet on the cleared endpoint judged against old value
    send(2, 1, int'(ref_tog[5]), 1, 0, 1, 1, 1, 2);
    send(2, 1, 1, 1, 0, 0, 0, 0, 0);
    send(2, 1, 0, 1, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule